// File: doc/BRIEF.md
# Circular Return Address Buffer

This block keeps a small ring of the most recently pushed return addresses next to the data-memory path. Whenever the core pushes a return address to the stack, it presents the same address on the push port, and the buffer records it. The stack write to memory still takes place as usual. When a return later pops that address, the core raises a pop request. On the following cycle the buffer reports a hit together with the cached address, so the core can use it without waiting for the memory read. On a miss the core falls back to the memory value, which means the result is the same whether or not the buffer is present.

The ring holds four entries by default and works as a stack. A pop returns the most recent entry and steps the read position back by one. A push into a full ring overwrites the oldest entry. A flush input empties the ring. Software that changes return addresses outside the normal push and pop sequence uses it so that the next return reads the real memory value.

Top module: `ret_addr_ring`

## Requirements
- R1: While reset is high and on the first cycle after it is released, `occupancy` is 0, `is_empty` is 1, `is_full` is 0 and `pop_hit` is 0.
- R2: A push with no pop and no flush stores `push_addr` as the newest entry and raises `occupancy` by one on the next cycle when the ring is not full.
- R3: A push into a full ring (occupancy equal to DEPTH) overwrites the oldest entry, and `occupancy` stays at DEPTH. After DEPTH+1 pushes, DEPTH pops return the last DEPTH addresses, newest first, and the next pop misses.
- R4: A pop while the ring is empty reports a miss: `pop_hit` is 0, `pop_addr` is 0 on the next cycle, and `occupancy` stays 0.
- R5: A pop while the ring is non-empty (no push, no flush) sets `pop_hit` to 1 on the next cycle, shows the newest entry on `pop_addr` for that one cycle, and lowers `occupancy` by one. The next pop returns the entry pushed just before it.
- R6: A flush without a push leaves `occupancy` at 0 on the next cycle, and a later pop misses.
- R7: A flush together with a push takes effect first: `occupancy` becomes 1, and the entry holds the new address.
- R8: A push together with a pop on a non-empty ring returns the previous newest entry with a hit and puts the new address in its place, so `occupancy` does not change. On an empty ring the pop misses and `occupancy` becomes 1.
- R9: A pop in the same cycle as a flush misses.
- R10: `is_full` is 1 exactly when `occupancy` equals DEPTH, and `is_empty` is 1 exactly when `occupancy` is 0. In any cycle with no pop hit, `pop_hit` is 0 and `pop_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_en | input | 1 | A return address is being pushed this cycle |
| push_addr | input | ADDR_W | Return address being pushed |
| pop_req | input | 1 | A return is popping its address this cycle |
| flush | input | 1 | Discard every cached entry |
| pop_hit | output | 1 | Registered: last cycle's pop was served from the ring |
| pop_addr | output | ADDR_W | Registered: cached address on a hit, zero otherwise |
| occupancy | output | $clog2(DEPTH+1) | Number of valid entries |
| is_full | output | 1 | Occupancy equals DEPTH |
| is_empty | output | 1 | Occupancy is zero |

## Verification
The bench targets the wrap point of the ring. It pushes past capacity and then drains the ring. A design that did not wrap, or did not saturate the count, would return stale addresses or report a hit on a fifth pop. It drives flush together with push, and flush together with pop. Applying these in the wrong order would either lose the new address or serve a hit from a ring that software has just invalidated. It also drives push and pop in the same cycle on full, partly filled and empty rings. Here a read-after-write ordering mistake would return the new address instead of the previous one, and a count mistake would drift the occupancy.

// File: rtl/rar_pkg.sv
package rar_pkg;
  function automatic int unsigned rar_cnt_width(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

  function automatic int unsigned rar_idx_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/rar_storage.sv
module rar_storage #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned IDX_W = rar_pkg::rar_idx_width(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_data
);
  logic [ADDR_W-1:0] mem [DEPTH];

  // read-first synchronous port pair, RAM-inferable
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_idx];
  end
endmodule

// File: rtl/rar_ptr_ctrl.sv
module rar_ptr_ctrl #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IDX_W = rar_pkg::rar_idx_width(DEPTH),
  localparam int unsigned CNT_W = rar_pkg::rar_cnt_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic             hit,
  output logic [IDX_W-1:0] rd_idx,
  output logic [IDX_W-1:0] wr_idx,
  output logic [CNT_W-1:0] count
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [IDX_W-1:0] head_q, head_after_pop, head_d;
  logic [CNT_W-1:0] eff_cnt, cnt_d;

  function automatic logic [IDX_W-1:0] idx_up(input logic [IDX_W-1:0] i);
    return (i == LAST_IDX) ? '0 : i + 1'b1;
  endfunction

  function automatic logic [IDX_W-1:0] idx_down(input logic [IDX_W-1:0] i);
    return (i == '0) ? LAST_IDX : i - 1'b1;
  endfunction

  always_comb begin
    // order inside a cycle: flush, then pop, then push
    eff_cnt        = flush ? '0 : count;
    hit            = pop && (eff_cnt != '0);
    rd_idx         = head_q;
    head_after_pop = hit ? idx_down(head_q) : head_q;
    wr_idx         = idx_up(head_after_pop);
    head_d         = push ? wr_idx : head_after_pop;
    cnt_d          = eff_cnt - CNT_W'(hit);
    if (push && cnt_d != FULL_CNT) cnt_d = cnt_d + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= LAST_IDX;
      count  <= '0;
    end else begin
      head_q <= head_d;
      count  <= cnt_d;
    end
  end
endmodule

// File: rtl/ret_addr_ring.sv
module ret_addr_ring #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned IDX_W = rar_pkg::rar_idx_width(DEPTH),
  localparam int unsigned CNT_W = rar_pkg::rar_cnt_width(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_en,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop_req,
  input  logic              flush,
  output logic              pop_hit,
  output logic [ADDR_W-1:0] pop_addr,
  output logic [CNT_W-1:0]  occupancy,
  output logic              is_full,
  output logic              is_empty
);
  logic             hit_now, hit_q;
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [ADDR_W-1:0] rd_data;

  rar_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .push   (push_en),
    .pop    (pop_req),
    .flush  (flush),
    .hit    (hit_now),
    .rd_idx (rd_idx),
    .wr_idx (wr_idx),
    .count  (occupancy)
  );

  rar_storage #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .wr_en   (push_en),
    .wr_idx  (wr_idx),
    .wr_data (push_addr),
    .rd_en   (hit_now),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= hit_now;
  end

  assign pop_hit  = hit_q;
  assign pop_addr = hit_q ? rd_data : '0;
  assign is_full  = (occupancy == CNT_W'(DEPTH));
  assign is_empty = (occupancy == '0);
endmodule

// File: rtl/rar_checker.sv
module rar_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned CNT_W = rar_pkg::rar_cnt_width(DEPTH)
) (
  input logic              clk,
  input logic              rst,
  input logic              push_en,
  input logic              pop_req,
  input logic              flush,
  input logic              pop_hit,
  input logic [ADDR_W-1:0] pop_addr,
  input logic [CNT_W-1:0]  occupancy,
  input logic              is_full,
  input logic              is_empty
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    occupancy <= CNT_W'(DEPTH));

  assert_push_grows_R2: assert property (@(posedge clk) disable iff (rst)
    push_en && !pop_req && !flush && !is_full |=> occupancy == $past(occupancy) + 1'b1);

  assert_empty_miss_R4: assert property (@(posedge clk) disable iff (rst)
    pop_req && is_empty && !push_en |=> !pop_hit && occupancy == '0);

  assert_pop_shrinks_R5: assert property (@(posedge clk) disable iff (rst)
    pop_req && !push_en && !flush && !is_empty |=> pop_hit && occupancy == $past(occupancy) - 1'b1);

  assert_flush_clears_R6: assert property (@(posedge clk) disable iff (rst)
    flush && !push_en |=> occupancy == '0);

  assert_flush_push_R7: assert property (@(posedge clk) disable iff (rst)
    flush && push_en |=> occupancy == CNT_W'(1));

  assert_swap_R8: assert property (@(posedge clk) disable iff (rst)
    push_en && pop_req && !flush && !is_empty |=> pop_hit && $stable(occupancy));

  assert_flush_pop_R9: assert property (@(posedge clk) disable iff (rst)
    flush |=> !pop_hit);

  assert_miss_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !pop_hit |-> pop_addr == '0);
endmodule

bind ret_addr_ring rar_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_rar_checker (
  .clk       (clk),
  .rst       (rst),
  .push_en   (push_en),
  .pop_req   (pop_req),
  .flush     (flush),
  .pop_hit   (pop_hit),
  .pop_addr  (pop_addr),
  .occupancy (occupancy),
  .is_full   (is_full),
  .is_empty  (is_empty)
);

// File: tb/test_ret_addr_ring.sv
`timescale 1ns/1ps
module test_ret_addr_ring;
  localparam int ADDR_W = 32;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push_en = 1'b0, pop_req = 1'b0, flush = 1'b0;
  logic [ADDR_W-1:0] push_addr = '0;
  logic pop_hit, is_full, is_empty;
  logic [ADDR_W-1:0] pop_addr;
  logic [CNT_W-1:0] occupancy;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model
  logic [ADDR_W-1:0] m_mem [DEPTH];
  int m_top = 0, m_cnt = 0;
  logic exp_hit;
  logic [ADDR_W-1:0] exp_addr;

  always #2.5 clk = ~clk;

  ret_addr_ring #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_ret_addr_ring (
    .clk(clk), .rst(rst), .push_en(push_en), .push_addr(push_addr),
    .pop_req(pop_req), .flush(flush), .pop_hit(pop_hit), .pop_addr(pop_addr),
    .occupancy(occupancy), .is_full(is_full), .is_empty(is_empty)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // model: flush first, then pop, then push
  task automatic model(input bit p, input logic [ADDR_W-1:0] a, input bit o, input bit f);
    if (f) m_cnt = 0;
    exp_hit  = o && (m_cnt > 0);
    exp_addr = '0;
    if (exp_hit) begin
      exp_addr = m_mem[m_top];
      m_top = (m_top + DEPTH - 1) % DEPTH;
      m_cnt--;
    end
    if (p) begin
      m_top = (m_top + 1) % DEPTH;
      m_mem[m_top] = a;
      if (m_cnt < DEPTH) m_cnt++;
    end
  endtask

  task automatic step(input string req, input bit p, input logic [ADDR_W-1:0] a,
                      input bit o, input bit f);
    @(negedge clk);
    push_en = p; push_addr = a; pop_req = o; flush = f;
    model(p, a, o, f);
    @(posedge clk);
    #1;
    push_en = 0; pop_req = 0; flush = 0;
    chk(req, "pop_hit", pop_hit, exp_hit);
    chk(req, "pop_addr", pop_addr, exp_addr);
    chk(req, "occupancy", occupancy, m_cnt);
    chk("R10", "is_full", is_full, m_cnt == DEPTH);
    chk("R10", "is_empty", is_empty, m_cnt == 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "occupancy in reset", occupancy, 0);
    chk("R1", "is_empty in reset", is_empty, 1);
    chk("R1", "pop_hit in reset", pop_hit, 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk("R1", "occupancy after reset", occupancy, 0);
    chk("R1", "is_full after reset", is_full, 0);

    step("R4", 0, 0, 1, 0);                        // pop on empty
    step("R2", 1, 32'h1000_0010, 0, 0);
    step("R2", 1, 32'h1000_0020, 0, 0);
    step("R5", 0, 0, 1, 0);                        // expect ...20
    step("R5", 0, 0, 1, 0);                        // expect ...10
    step("R4", 0, 0, 1, 0);
    for (int i = 1; i <= DEPTH + 1; i++) step("R3", 1, 32'hA000_0000 + i, 0, 0);
    for (int i = 0; i <= DEPTH; i++) step("R3", 0, 0, 1, 0);  // 5,4,3,2 then miss
    step("R2", 1, 32'h0000_0B00, 0, 0);
    step("R2", 1, 32'h0000_0B04, 0, 0);
    step("R6", 0, 0, 0, 1);
    step("R6", 0, 0, 1, 0);
    step("R2", 1, 32'h0000_0C00, 0, 0);
    step("R7", 1, 32'h0000_0C44, 0, 1);
    step("R7", 0, 0, 1, 0);                        // returns C44
    step("R4", 0, 0, 1, 0);
    step("R8", 1, 32'h0000_0D00, 1, 0);            // empty: miss, count 1
    step("R8", 1, 32'h0000_0D10, 1, 0);            // returns D00
    step("R8", 0, 0, 1, 0);                        // returns D10
    for (int i = 0; i < DEPTH; i++) step("R2", 1, 32'hE000_0000 + i, 0, 0);
    step("R8", 1, 32'hE000_00FF, 1, 0);            // full swap
    step("R9", 0, 0, 1, 1);
    step("R9", 0, 0, 1, 0);

    void'($urandom(32'd20260));
    for (int n = 0; n < 3000; n++) begin
      bit p, o, f;
      int r = $urandom_range(0, 99);
      p = (r < 45);
      o = ($urandom_range(0, 99) < 45);
      f = ($urandom_range(0, 99) < 4);
      step(f ? (p ? "R7" : "R6") : (p && o) ? "R8" : o ? "R5" : "R2",
           p, $urandom(), o, f);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule